// File: doc/BRIEF.md
# I2C Controller Register Block

This block is the control and status register file of an I2C master controller. Software reaches it through a simple 32-bit register port with a one-cycle read latency. It stores the controller's configuration: the control word, the target and own-device addresses, and the receive and transmit FIFO thresholds. It also holds the enable register, which switches the controller on, blocks command issue and requests an abort. A status word is assembled live from the sequencer's idle indication and the FIFO fill levels.

Towards the rest of the controller, the block drives the enable, command-block and abort levels. It also sends a one-cycle user-abort pulse to the command sequencer and a one-cycle flush pulse to both FIFOs. The abort request is tracked by a two-state machine. In `ABT_CLEAR` no abort is pending. Writing the abort bit while the sequencer is busy moves it to `ABT_ARMED` and emits the user-abort pulse. Writing the abort bit while the sequencer is idle leaves it in `ABT_CLEAR`, so the bit drops at once. A stop-completed indication from the sequencer takes it from `ABT_ARMED` back to `ABT_CLEAR`.

Register offsets: control 0x00, target address 0x04, own address 0x08, RX threshold 0x0C, TX threshold 0x10, enable 0x14, status 0x18, TX level 0x1C, RX level 0x20.

Top module: `i2c_cfg_regfile`

## Requirements
- R1: After reset, control reads 0x65 (master mode, speed code 2, repeated start on, slave function off), both addresses read 0x55, both thresholds and the enable register read 0.
- R2: The control word keeps bits 6:0 of a write: bit 0 master mode, bits 2:1 speed code, bit 3 10-bit own addressing, bit 4 10-bit target addressing, bit 5 repeated-start enable, bit 6 slave disable. Higher bits read as 0.
- R3: A control write with speed code 0 stores speed code 3, and all other written bits are kept as written. The stored speed code is never 0.
- R4: Writes to the target and own-address registers keep only the low 10 bits.
- R5: A threshold write takes the low 8 bits and clamps the result to the FIFO depth (16).
- R6: The enable register has bit 0 enable and bit 2 command block, both stored as written and driven out as levels. Bit 1 is abort.
- R7: Writing abort=1 while the sequencer is idle leaves the abort bit reading 0 and produces no user-abort pulse.
- R8: Writing abort=1 while the sequencer is busy raises a one-cycle user-abort pulse and sets the abort bit. Later writes of 0 do not clear it. It clears in the cycle after the stop-completed indication.
- R9: Any enable-register write with bit 0 = 0 gives a one-cycle FIFO flush pulse in the following cycle. A write with bit 0 = 1 gives none.
- R10: The status word has bit 0 activity, bit 1 TX not full, bit 2 TX empty, bit 3 RX not empty, bit 4 RX full and bit 5 controller activity. Bits 0 and 5 are both 1 whenever the sequencer is not idle.
- R11: The TX and RX level registers read the current FIFO item counts.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| seq_idle | input | 1 | Command sequencer is idle |
| seq_stop_done | input | 1 | Sequencer finished a stop condition |
| tx_level | input | 5 | TX FIFO item count |
| rx_level | input | 5 | RX FIFO item count |
| cfg_ctrl | output | 7 | Stored control word |
| cfg_target | output | 10 | Target address |
| cfg_own | output | 10 | Own-device address |
| cfg_rx_thresh | output | 5 | RX FIFO threshold |
| cfg_tx_thresh | output | 5 | TX FIFO threshold |
| ctl_enable | output | 1 | Controller enable |
| ctl_cmd_block | output | 1 | Block command issue |
| ctl_abort | output | 1 | Abort pending |
| ctl_user_abort | output | 1 | One-cycle user-abort pulse to the sequencer |
| ctl_fifo_flush | output | 1 | One-cycle flush of both FIFOs |

## Verification
The hardest situation to reach is an abort held across several writes while a transfer is in flight. That state only exists while the sequencer reports busy and no stop has arrived. The bench holds the sequencer-idle input low and then writes the abort bit. It next writes the enable register with the abort bit cleared to confirm the bit is sticky. Only then does it pulse the stop-completed input and read the abort bit back as 0.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TGT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OWN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RXTH = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXTH = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TXLV = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RXLV = 8'h20;

    typedef enum logic {
        ABT_CLEAR = 1'b0,
        ABT_ARMED = 1'b1
    } abt_state_t;

    typedef struct packed {
        logic       slave_off;
        logic       restart_en;
        logic       tgt_addr10;
        logic       own_addr10;
        logic [1:0] speed;
        logic       master;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{
        slave_off:  1'b1,
        restart_en: 1'b1,
        tgt_addr10: 1'b0,
        own_addr10: 1'b0,
        speed:      2'd2,
        master:     1'b1
    };
endpackage

// File: rtl/i2cr_cfg_regs.sv
module i2cr_cfg_regs
    import i2cr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TADDR_W    = 10,
    parameter int THR_IN_W   = 8,
    parameter logic [TADDR_W-1:0] ADDR_RST = 10'h055,
    localparam int THR_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output ctrl_t                ctrl_q,
    output logic [TADDR_W-1:0]   tgt_q,
    output logic [TADDR_W-1:0]   own_q,
    output logic [1:0][THR_W-1:0] thr_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        if (ctrl_d.speed == 2'b00) begin
            ctrl_d.speed = 2'b11;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            tgt_q  <= ADDR_RST;
            own_q  <= ADDR_RST;
        end else if (wr_en) begin
            if (addr == OFS_CTRL) ctrl_q <= ctrl_d;
            if (addr == OFS_TGT)  tgt_q  <= wdata[TADDR_W-1:0];
            if (addr == OFS_OWN)  own_q  <= wdata[TADDR_W-1:0];
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_thr
        localparam logic [ADDR_W-1:0] OFS = (i == 0) ? OFS_RXTH : OFS_TXTH;
        logic [THR_IN_W-1:0] raw;
        logic [THR_W-1:0]    clamped;

        always_comb begin
            raw = wdata[THR_IN_W-1:0];
            if (int'(raw) > FIFO_DEPTH) clamped = THR_W'(FIFO_DEPTH);
            else                        clamped = THR_W'(raw);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        thr_q[i] <= '0;
            else if (wr_en && addr == OFS)     thr_q[i] <= clamped;
        end

        // R5: a threshold never exceeds the FIFO depth
        p_thr_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
            int'(thr_q[i]) <= FIFO_DEPTH);
    end

    // R3: stored speed code is never zero
    p_speed_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.speed != 2'b00);

    // R2: a control write is visible on the next cycle, speed aside
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL) |=>
        (ctrl_q.master == $past(wdata[0]) && ctrl_q.slave_off == $past(wdata[6])));
endmodule

// File: rtl/i2cr_enable_fsm.sv
module i2cr_enable_fsm
    import i2cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic [2:0] en_wdata,
    input  logic       seq_idle,
    input  logic       stop_done,
    output logic       enable_o,
    output logic       cmd_block_o,
    output logic       abort_o,
    output logic       user_abort_o,
    output logic       flush_o
);
    abt_state_t state_q, state_d;
    logic       abort_req;

    assign abort_req = en_wr && en_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ABT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ABT_CLEAR: if (abort_req && !seq_idle) state_d = ABT_ARMED;
            ABT_ARMED: if (stop_done)              state_d = ABT_CLEAR;
            default:                               state_d = ABT_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_o     <= 1'b0;
            cmd_block_o  <= 1'b0;
            user_abort_o <= 1'b0;
            flush_o      <= 1'b0;
        end else begin
            user_abort_o <= (state_q == ABT_CLEAR) && abort_req && !seq_idle;
            flush_o      <= en_wr && !en_wdata[0];
            if (en_wr) begin
                enable_o    <= en_wdata[0];
                cmd_block_o <= en_wdata[2];
            end
        end
    end

    assign abort_o = (state_q == ABT_ARMED);

    p_idle_abort_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && seq_idle && !abort_o) |=> !abort_o);

    p_abort_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !stop_done) |=> abort_o);

    p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && stop_done) |=> !abort_o);

    p_uabort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        user_abort_o |=> !user_abort_o);

    p_flush_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata[0]) |=> flush_o);
endmodule

// File: rtl/i2cr_read_mux.sv
module i2cr_read_mux
    import i2cr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TADDR_W    = 10,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  ctrl_t                 ctrl,
    input  logic [TADDR_W-1:0]    tgt,
    input  logic [TADDR_W-1:0]    own,
    input  logic [1:0][LVL_W-1:0] thr,
    input  logic [2:0]            en_word,
    input  logic                  seq_idle,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    output logic [DATA_W-1:0]     rdata_q
);
    logic              busy, tx_full, tx_empty, rx_full, rx_empty;
    logic [5:0]        stat;
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        busy     = !seq_idle;
        tx_full  = (tx_level == LVL_W'(FIFO_DEPTH));
        tx_empty = (tx_level == '0);
        rx_full  = (rx_level == LVL_W'(FIFO_DEPTH));
        rx_empty = (rx_level == '0);
        stat     = {busy, rx_full, !rx_empty, tx_empty, !tx_full, busy};
    end

    always_comb begin
        rdata_d = '0;
        case (addr)
            OFS_CTRL: rdata_d = DATA_W'(ctrl);
            OFS_TGT:  rdata_d = DATA_W'(tgt);
            OFS_OWN:  rdata_d = DATA_W'(own);
            OFS_RXTH: rdata_d = DATA_W'(thr[0]);
            OFS_TXTH: rdata_d = DATA_W'(thr[1]);
            OFS_EN:   rdata_d = DATA_W'(en_word);
            OFS_STAT: rdata_d = DATA_W'(stat);
            OFS_TXLV: rdata_d = DATA_W'(tx_level);
            OFS_RXLV: rdata_d = DATA_W'(rx_level);
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rdata_d;
    end

    p_status_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_STAT && !seq_idle) |=> (rdata_q[0] && rdata_q[5]));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr > OFS_RXLV || addr[1:0] != 2'b00)) |=> (rdata_q == '0));

    p_level_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_TXLV) |=> (rdata_q == DATA_W'($past(tx_level))));
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2cr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TADDR_W    = 10,
    parameter int THR_IN_W   = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               seq_idle,
    input  logic               seq_stop_done,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    output logic [6:0]         cfg_ctrl,
    output logic [TADDR_W-1:0] cfg_target,
    output logic [TADDR_W-1:0] cfg_own,
    output logic [LVL_W-1:0]   cfg_rx_thresh,
    output logic [LVL_W-1:0]   cfg_tx_thresh,
    output logic               ctl_enable,
    output logic               ctl_cmd_block,
    output logic               ctl_abort,
    output logic               ctl_user_abort,
    output logic               ctl_fifo_flush
);
    ctrl_t                 ctrl_q;
    logic [1:0][LVL_W-1:0] thr_q;
    logic                  en_wr;

    assign en_wr = reg_wr && (reg_addr == OFS_EN);

    i2cr_cfg_regs #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .TADDR_W    (TADDR_W),
        .THR_IN_W   (THR_IN_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q),
        .tgt_q  (cfg_target),
        .own_q  (cfg_own),
        .thr_q  (thr_q)
    );

    i2cr_enable_fsm u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_wr        (en_wr),
        .en_wdata     (reg_wdata[2:0]),
        .seq_idle     (seq_idle),
        .stop_done    (seq_stop_done),
        .enable_o     (ctl_enable),
        .cmd_block_o  (ctl_cmd_block),
        .abort_o      (ctl_abort),
        .user_abort_o (ctl_user_abort),
        .flush_o      (ctl_fifo_flush)
    );

    i2cr_read_mux #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .TADDR_W    (TADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .ctrl     (ctrl_q),
        .tgt      (cfg_target),
        .own      (cfg_own),
        .thr      (thr_q),
        .en_word  ({ctl_cmd_block, ctl_abort, ctl_enable}),
        .seq_idle (seq_idle),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .rdata_q  (reg_rdata)
    );

    assign cfg_ctrl      = ctrl_q;
    assign cfg_rx_thresh = thr_q[0];
    assign cfg_tx_thresh = thr_q[1];

    p_no_wr_rd_sideeffect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> ($stable(ctl_enable) && $stable(ctl_cmd_block)));
endmodule

// File: tb/tb_i2c_cfg_regfile.sv
`timescale 1ns/1ps
module tb_i2c_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_idle = 1'b1, seq_stop_done = 1'b0;
    logic [4:0]  tx_level = '0, rx_level = '0;
    logic [6:0]  cfg_ctrl;
    logic [9:0]  cfg_target, cfg_own;
    logic [4:0]  cfg_rx_thresh, cfg_tx_thresh;
    logic        ctl_enable, ctl_cmd_block, ctl_abort, ctl_user_abort, ctl_fifo_flush;

    int n_checks = 0;
    int n_fails  = 0;
    logic last_flush, last_uabort;
    logic [31:0] rd;

    always #10 clk = ~clk;

    i2c_cfg_regfile dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_idle(seq_idle), .seq_stop_done(seq_stop_done),
        .tx_level(tx_level), .rx_level(rx_level),
        .cfg_ctrl(cfg_ctrl), .cfg_target(cfg_target), .cfg_own(cfg_own),
        .cfg_rx_thresh(cfg_rx_thresh), .cfg_tx_thresh(cfg_tx_thresh),
        .ctl_enable(ctl_enable), .ctl_cmd_block(ctl_cmd_block),
        .ctl_abort(ctl_abort), .ctl_user_abort(ctl_user_abort),
        .ctl_fifo_flush(ctl_fifo_flush)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        last_flush  = ctl_fifo_flush;
        last_uabort = ctl_user_abort;
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset_r1();
        rdreg(8'h00, rd); check("R1 ctrl", rd, 32'h65);
        rdreg(8'h04, rd); check("R1 target", rd, 32'h55);
        rdreg(8'h08, rd); check("R1 own", rd, 32'h55);
        rdreg(8'h0C, rd); check("R1 rx thresh", rd, 32'h0);
        rdreg(8'h10, rd); check("R1 tx thresh", rd, 32'h0);
        rdreg(8'h14, rd); check("R1 enable", rd, 32'h0);
    endtask

    task automatic t_ctrl_r2_r3();
        wr(8'h00, 32'hFFFF_FF3A);
        rdreg(8'h00, rd); check("R2 ctrl kept bits", rd, 32'h3A);
        check("R2 ctrl port", {25'b0, cfg_ctrl}, 32'h3A);
        wr(8'h00, 32'h0000_0011);
        rdreg(8'h00, rd); check("R3 speed 0 remapped to 3", rd, 32'h17);
        wr(8'h00, 32'h0000_0078);
        rdreg(8'h00, rd); check("R3 remap keeps others", rd, 32'h7E);
    endtask

    task automatic t_addr_r4();
        wr(8'h04, 32'hFFFF_F7AB);
        rdreg(8'h04, rd); check("R4 target low 10 bits", rd, 32'h3AB);
        wr(8'h08, 32'h0000_1234);
        rdreg(8'h08, rd); check("R4 own low 10 bits", rd, 32'h234);
    endtask

    task automatic t_thresh_r5();
        wr(8'h0C, 32'h0000_010F);
        rdreg(8'h0C, rd); check("R5 rx low 8 bits", rd, 32'd15);
        wr(8'h0C, 32'h0000_0010);
        rdreg(8'h0C, rd); check("R5 rx at depth", rd, 32'd16);
        wr(8'h0C, 32'h0000_0011);
        rdreg(8'h0C, rd); check("R5 rx depth+1 clamped", rd, 32'd16);
        wr(8'h10, 32'h0000_00FF);
        rdreg(8'h10, rd); check("R5 tx clamped", rd, 32'd16);
        wr(8'h10, 32'h0000_0305);
        rdreg(8'h10, rd); check("R5 tx low 8 bits", rd, 32'd5);
    endtask

    task automatic t_enable_r6_r9();
        wr(8'h14, 32'h0000_0005);
        check("R9 no flush when enabling", {31'b0, last_flush}, 32'h0);
        rdreg(8'h14, rd); check("R6 enable word", rd, 32'h5);
        check("R6 enable out", {31'b0, ctl_enable}, 32'h1);
        check("R6 cmd block out", {31'b0, ctl_cmd_block}, 32'h1);
        wr(8'h14, 32'h0000_0000);
        check("R9 flush pulse", {31'b0, last_flush}, 32'h1);
        @(negedge clk);
        check("R9 flush one cycle", {31'b0, ctl_fifo_flush}, 32'h0);
        check("R6 enable cleared", {31'b0, ctl_enable}, 32'h0);
    endtask

    task automatic t_abort_idle_r7();
        seq_idle = 1'b1;
        wr(8'h14, 32'h0000_0003);
        check("R7 no user abort", {31'b0, last_uabort}, 32'h0);
        rdreg(8'h14, rd); check("R7 abort drops", rd, 32'h1);
    endtask

    task automatic t_abort_busy_r8();
        seq_idle = 1'b0;
        wr(8'h14, 32'h0000_0003);
        check("R8 user abort pulse", {31'b0, last_uabort}, 32'h1);
        rdreg(8'h14, rd); check("R8 abort set", rd, 32'h3);
        wr(8'h14, 32'h0000_0001);
        check("R8 no second pulse", {31'b0, last_uabort}, 32'h0);
        rdreg(8'h14, rd); check("R8 abort not cleared by write", rd, 32'h3);
        @(negedge clk);
        seq_stop_done = 1'b1;
        @(negedge clk);
        seq_stop_done = 1'b0;
        seq_idle = 1'b1;
        check("R8 abort out cleared", {31'b0, ctl_abort}, 32'h0);
        rdreg(8'h14, rd); check("R8 abort cleared after stop", rd, 32'h1);
    endtask

    task automatic t_status_r10_r11();
        seq_idle = 1'b1; tx_level = 5'd0; rx_level = 5'd0;
        rdreg(8'h18, rd); check("R10 idle empty", rd, 32'h06);
        seq_idle = 1'b0; tx_level = 5'd16; rx_level = 5'd16;
        rdreg(8'h18, rd); check("R10 busy full", rd, 32'h39);
        seq_idle = 1'b1; tx_level = 5'd5; rx_level = 5'd3;
        rdreg(8'h18, rd); check("R10 partial", rd, 32'h0A);
        rdreg(8'h1C, rd); check("R11 tx level", rd, 32'd5);
        rdreg(8'h20, rd); check("R11 rx level", rd, 32'd3);
    endtask

    task automatic t_unmapped_r12();
        rdreg(8'h40, rd); check("R12 unmapped 0x40", rd, 32'h0);
        rdreg(8'h24, rd); check("R12 unmapped 0x24", rd, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        rdreg(8'h00, rd); check("R12 ctrl untouched", rd, 32'h7E);
        rdreg(8'h04, rd); check("R12 target untouched", rd, 32'h3AB);
        rdreg(8'h10, rd); check("R12 tx thresh untouched", rd, 32'd5);
        rdreg(8'h14, rd); check("R12 enable untouched", rd, 32'h1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_ctrl_r2_r3();
        t_addr_r4();
        t_thresh_r5();
        t_enable_r6_r9();
        t_abort_idle_r7();
        t_abort_busy_r8();
        t_status_r10_r11();
        t_unmapped_r12();
        finish_run();
    end
endmodule